// File: doc/BRIEF.md
# Cable Power Level Controller

This block sits on the cable side of an active cable's management logic. The host writes two control bits: an override that permits high power and a low-set bit that forces low power. The cable holds read-only capability fields: a 2-bit power class identifier, a 4-bit reduced-power code and a 3-bit minimum-supply-voltage code. When the host's register write completes, a one-cycle strobe arrives. On that strobe the block captures the inputs, decides the power class the cable may draw, and sequences the enable for the transmit and receive circuitry.

Low power is entered on the strobe edge itself, with no delay. High power is entered by raising the enable at once. Full function is reported only after a parameterised settle interval, which must fit inside the deadline for leaving low power. The two capability codes are decoded to compact level numbers. A reserved code is reported as "not supported" and latches an error flag that only reset clears.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block responds to inputs from the third clock edge after the release.

Top module: `pwr_level_ctrl`

## Requirements
- R1: After reset, `pwr_class_o`, `hp_enable_o`, `func_ready_o`, `lowpwr_lvl_o`, `vmin_lvl_o` and `cap_err_o` are all 0.
- R2: The block acts on the inputs only in a cycle where `wr_done_i` is 1. Input changes in other cycles leave every output unchanged.
- R3: A strobe with the override at 0 sets `pwr_class_o` to 0, which is the 1.5 W class.
- R4: A strobe with override 1 and low-set 0 sets `pwr_class_o` equal to the identifier. The class codes are 0 = 1.5 W, 1 = 2.0 W, 2 = 2.5 W and 3 = 3.5 W.
- R5: A strobe with both override and low-set at 1 sets `pwr_class_o` to 0.
- R6: A strobe with identifier 00 leaves `hp_enable_o` at 1 in every mode. In that case `func_ready_o` is 1 once the settle interval has passed.
- R7: A strobe that selects low power with a nonzero identifier drives `hp_enable_o` and `func_ready_o` to 0 on that same clock edge.
- R8: A strobe that selects high power while the enable is off raises `hp_enable_o` on that edge. `func_ready_o` then rises exactly SETTLE_CYC edges later, which is no more than HP_DEADLINE_CYC.
- R9: `lowpwr_lvl_o` decodes the 4-bit reduced-power code: 0000 gives 0 (not supported), 0001 gives 1 (1 W), 0010 gives 2 (0.75 W), 0011 gives 3 (0.5 W). Every other code gives 0.
- R10: `vmin_lvl_o` decodes the 3-bit voltage code: 000 gives 0 (nominal 3.3 V), 001 gives 1 (2.3 V), 010 gives 2 (1.7 V). Every other code gives 0.
- R11: A strobe that carries a reserved code in either capability field sets `cap_err_o`. It stays at 1 until reset.
- R12: A strobe requesting high power while the enable is already on does not restart settling. A ready output stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_done_i | input | 1 | One-cycle strobe when the host write completes |
| ctl_override_i | input | 1 | Host bit that permits high power |
| ctl_lowset_i | input | 1 | Host bit that forces low power when override is set |
| cap_pwr_id_i | input | 2 | Read-only power class identifier |
| cap_lowpwr_code_i | input | 4 | Read-only reduced-power code |
| cap_vmin_code_i | input | 3 | Read-only minimum-voltage code |
| pwr_class_o | output | 2 | Allowed power class (0 = 1.5 W … 3 = 3.5 W) |
| hp_enable_o | output | 1 | Enable for transmit/receive circuitry |
| func_ready_o | output | 1 | Fully functional status |
| lowpwr_lvl_o | output | 2 | Decoded reduced-power level |
| vmin_lvl_o | output | 2 | Decoded minimum-voltage level |
| cap_err_o | output | 1 | Sticky reserved-code flag |

## Verification
The assertions assume that `wr_done_i` is a single-cycle pulse. They also assume that the inputs are stable in the cycle the strobe is high. The assertions rely on the internally synchronised reset, so no strobe is expected while that reset is still being released.

The bench drives every input at the falling edge and holds the strobe for exactly one cycle. It waits out the reset release before its first write. It always waits longer than the settle interval between a preparatory write and the write under test, so the prior state is known.

// File: rtl/pwr_level_pkg.sv
package pwr_level_pkg;
  localparam int LVL_W = 2;

  typedef enum logic [1:0] {
    SEQ_OFF    = 2'd0,
    SEQ_SETTLE = 2'd1,
    SEQ_ON     = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic             override;
    logic             lowset;
    logic [LVL_W-1:0] pwr_id;
  } ctl_req_t;
endpackage

// File: rtl/pwr_req_decode.sv
module pwr_req_decode
  import pwr_level_pkg::*;
(
  input  ctl_req_t         req_i,
  output logic [LVL_W-1:0] class_o,
  output logic             want_hp_o
);
  logic high_ok;

  always_comb begin
    high_ok   = req_i.override & ~req_i.lowset;
    class_o   = high_ok ? req_i.pwr_id : '0;
    // Identifier 00 keeps the circuitry running whatever the mode.
    want_hp_o = high_ok | (req_i.pwr_id == '0);
  end
endmodule

// File: rtl/pwr_cap_decode.sv
module pwr_cap_decode #(
  parameter int CODE_W   = 4,
  parameter int CODE_MAX = 3,
  parameter int LVL_W    = 2
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [LVL_W-1:0]  lvl_o,
  output logic              reserved_o
);
  always_comb begin
    if (int'(code_i) <= CODE_MAX) begin
      lvl_o      = LVL_W'(code_i);
      reserved_o = 1'b0;
    end else begin
      lvl_o      = '0;
      reserved_o = 1'b1;
    end
  end
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_level_pkg::*;
#(
  parameter int SETTLE_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_i,
  input  logic want_i,
  output logic hp_en_o,
  output logic ready_o
);
  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYC - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      SEQ_OFF: begin
        if (upd_i && want_i) begin
          state_d = SEQ_SETTLE;
          cnt_d   = LOAD;
        end
      end
      SEQ_SETTLE: begin
        if (upd_i && !want_i) begin
          state_d = SEQ_OFF;
        end else if (cnt_q == '0) begin
          state_d = SEQ_ON;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SEQ_ON: begin
        if (upd_i && !want_i) state_d = SEQ_OFF;
      end
      default: state_d = SEQ_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign hp_en_o = (state_q != SEQ_OFF);
  assign ready_o = (state_q == SEQ_ON);
endmodule

// File: rtl/pwr_level_ctrl.sv
module pwr_level_ctrl
  import pwr_level_pkg::*;
#(
  parameter int SETTLE_CYC      = 12,
  parameter int HP_DEADLINE_CYC = 20,
  parameter int ALP_W           = 4,
  parameter int VMIN_W          = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_done_i,
  input  logic              ctl_override_i,
  input  logic              ctl_lowset_i,
  input  logic [1:0]        cap_pwr_id_i,
  input  logic [ALP_W-1:0]  cap_lowpwr_code_i,
  input  logic [VMIN_W-1:0] cap_vmin_code_i,
  output logic [1:0]        pwr_class_o,
  output logic              hp_enable_o,
  output logic              func_ready_o,
  output logic [1:0]        lowpwr_lvl_o,
  output logic [1:0]        vmin_lvl_o,
  output logic              cap_err_o
);
  localparam int ALP_MAX  = 3;
  localparam int VMIN_MAX = 2;

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  ctl_req_t         req;
  logic [LVL_W-1:0] class_c;
  logic             want_c;
  logic [LVL_W-1:0] alp_c, vmin_c;
  logic             alp_res, vmin_res;

  assign req = '{override: ctl_override_i, lowset: ctl_lowset_i, pwr_id: cap_pwr_id_i};

  pwr_req_decode u_req (
    .req_i     (req),
    .class_o   (class_c),
    .want_hp_o (want_c)
  );

  pwr_cap_decode #(.CODE_W(ALP_W), .CODE_MAX(ALP_MAX), .LVL_W(LVL_W)) u_alp (
    .code_i     (cap_lowpwr_code_i),
    .lvl_o      (alp_c),
    .reserved_o (alp_res)
  );

  pwr_cap_decode #(.CODE_W(VMIN_W), .CODE_MAX(VMIN_MAX), .LVL_W(LVL_W)) u_vmin (
    .code_i     (cap_vmin_code_i),
    .lvl_o      (vmin_c),
    .reserved_o (vmin_res)
  );

  pwr_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .upd_i   (wr_done_i),
    .want_i  (want_c),
    .hp_en_o (hp_enable_o),
    .ready_o (func_ready_o)
  );

  logic [LVL_W-1:0] class_q, class_d, alp_q, alp_d, vmin_q, vmin_d;
  logic             err_q, err_d;

  always_comb begin
    class_d = class_q;
    alp_d   = alp_q;
    vmin_d  = vmin_q;
    err_d   = err_q;
    if (wr_done_i) begin
      class_d = class_c;
      alp_d   = alp_c;
      vmin_d  = vmin_c;
      err_d   = err_q | alp_res | vmin_res;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      class_q <= '0;
      alp_q   <= '0;
      vmin_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      class_q <= class_d;
      alp_q   <= alp_d;
      vmin_q  <= vmin_d;
      err_q   <= err_d;
    end
  end

  assign pwr_class_o  = class_q;
  assign lowpwr_lvl_o = alp_q;
  assign vmin_lvl_o   = vmin_q;
  assign cap_err_o    = err_q;
endmodule

// File: rtl/pwr_level_ctrl_chk.sv
module pwr_level_ctrl_chk #(
  parameter int HP_DEADLINE_CYC = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_done_i,
  input logic       ctl_override_i,
  input logic       ctl_lowset_i,
  input logic [1:0] cap_pwr_id_i,
  input logic [1:0] pwr_class_o,
  input logic       hp_enable_o,
  input logic       func_ready_o,
  input logic       cap_err_o
);
  localparam int WC_W = $clog2(HP_DEADLINE_CYC + 2);
  logic [WC_W-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_cnt <= '0;
    else if (hp_enable_o && !func_ready_o) begin
      if (int'(wait_cnt) <= HP_DEADLINE_CYC) wait_cnt <= wait_cnt + 1'b1;
    end else wait_cnt <= '0;
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_done_i |=> $stable(pwr_class_o));
  p_fixed_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done_i && !ctl_override_i |=> pwr_class_o == 2'd0);
  p_id_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done_i && ctl_override_i && !ctl_lowset_i |=> pwr_class_o == $past(cap_pwr_id_i));
  p_forced_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done_i && ctl_override_i && ctl_lowset_i |=> pwr_class_o == 2'd0);
  p_basic_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done_i && cap_pwr_id_i == 2'd0 |=> hp_enable_o);
  p_lowpwr_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done_i && cap_pwr_id_i != 2'd0 && !(ctl_override_i && !ctl_lowset_i)
    |=> !hp_enable_o && !func_ready_o);
  p_ready_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    func_ready_o |-> hp_enable_o);
  p_settle_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wait_cnt) <= HP_DEADLINE_CYC);
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cap_err_o |=> cap_err_o);
endmodule

bind pwr_level_ctrl pwr_level_ctrl_chk #(.HP_DEADLINE_CYC(HP_DEADLINE_CYC)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n_s),
  .wr_done_i      (wr_done_i),
  .ctl_override_i (ctl_override_i),
  .ctl_lowset_i   (ctl_lowset_i),
  .cap_pwr_id_i   (cap_pwr_id_i),
  .pwr_class_o    (pwr_class_o),
  .hp_enable_o    (hp_enable_o),
  .func_ready_o   (func_ready_o),
  .cap_err_o      (cap_err_o)
);

// File: tb/pwr_level_ctrl_bench.sv
module pwr_level_ctrl_bench;
  localparam int S = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, ovr = 1'b0, lset = 1'b0;
  logic [1:0] pid = '0;
  logic [3:0] alp = '0;
  logic [2:0] vmn = '0;
  logic [1:0] cls, alp_l, vmn_l;
  logic       hp, rdy, err;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_level_ctrl #(.SETTLE_CYC(S), .HP_DEADLINE_CYC(20)) u_pwr_level_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_done_i(wr), .ctl_override_i(ovr),
    .ctl_lowset_i(lset), .cap_pwr_id_i(pid), .cap_lowpwr_code_i(alp),
    .cap_vmin_code_i(vmn), .pwr_class_o(cls), .hp_enable_o(hp),
    .func_ready_o(rdy), .lowpwr_lvl_o(alp_l), .vmin_lvl_o(vmn_l), .cap_err_o(err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Apply control index: bit3 override, bit2 low-set, bits1:0 identifier.
  task automatic do_write(input int idx);
    ovr  = idx[3];
    lset = idx[2];
    pid  = idx[1:0];
    wr   = 1'b1;
    @(negedge clk);
    wr   = 1'b0;
  endtask

  function automatic bit want_of(input int idx);
    return (idx[3] && !idx[2]) || (idx[1:0] == 0);
  endfunction

  function automatic int class_of(input int idx);
    return (idx[3] && !idx[2]) ? (idx & 3) : 0;
  endfunction

  initial begin
    do_reset();
    chk("R1 class", cls, 0); chk("R1 hp", hp, 0); chk("R1 ready", rdy, 0);
    chk("R1 alp", alp_l, 0); chk("R1 vmin", vmn_l, 0); chk("R1 err", err, 0);

    // Exhaustive transitions between all control combinations.
    for (int p = 0; p < 16; p++) begin
      for (int n = 0; n < 16; n++) begin
        do_write(p);
        wait_n(S + 2);
        do_write(n);
        chk(n[3] ? (n[2] ? "R5 class" : "R4 class") : "R3 class", cls, class_of(n));
        if (n[1:0] == 0)      chk("R6 hp", hp, 1);
        else if (want_of(n))  chk("R8 hp", hp, 1);
        else begin            chk("R7 hp", hp, 0); chk("R7 ready", rdy, 0); end
        if (want_of(n) && want_of(p)) begin
          chk("R12 ready kept", rdy, 1);
          wait_n(S - 1);
          chk("R12 ready kept late", rdy, 1);
        end else if (want_of(n)) begin
          chk("R8 ready early", rdy, 0);
          wait_n(S - 1);
          chk("R8 ready before settle", rdy, 0);
          wait_n(1);
          chk(n[1:0] == 0 ? "R6 ready" : "R8 ready at settle", rdy, 1);
        end
      end
    end

    // R2: inputs change without a strobe.
    do_write(4'b1011);
    wait_n(S + 2);
    ovr = 1'b0; pid = 2'd1; alp = 4'd2; vmn = 3'd1;
    wait_n(5);
    chk("R2 class held", cls, 3); chk("R2 hp held", hp, 1); chk("R2 ready held", rdy, 1);
    chk("R2 alp held", alp_l, 0); chk("R2 vmin held", vmn_l, 0);

    // R9 / R11: sweep reduced-power code, voltage code valid.
    do_reset();
    vmn = 3'd0;
    for (int c = 0; c < 16; c++) begin
      alp = c[3:0];
      do_write(0);
      chk("R9 alp level", alp_l, (c <= 3) ? c : 0);
      chk("R11 err", err, (c >= 4) ? 1 : 0);
    end
    alp = 4'd1; do_write(0);
    chk("R11 err sticky", err, 1);

    // R10 / R11: sweep voltage code after reset.
    do_reset();
    chk("R1 err cleared", err, 0);
    alp = 4'd0;
    for (int c = 0; c < 8; c++) begin
      vmn = c[2:0];
      do_write(0);
      chk("R10 vmin level", vmn_l, (c <= 2) ? c : 0);
      chk("R11 err", err, (c >= 3) ? 1 : 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule